// File: doc/BRIEF.md
# Byte-Lane Load/Store Data Unit

This block is the memory-stage data path of a 32-bit core. It holds the word-organised data RAM and handles access sizes on both sides of it. A store of a byte, halfword or word is turned into a set of byte-lane write enables and a write word in which the store data is repeated across the lanes. A load picks the addressed byte or halfword out of the word that was read, moves it down to the low bits, and fills the upper bits either with copies of its top bit or with zeros.

The RAM reads and writes on the falling clock edge. A request presented after a rising edge is therefore carried out halfway through that cycle. The lane extraction and extension logic runs after the read, and the load result settles before the next rising edge, so the same stage can use it. Address bits above the RAM range are ignored, so the array repeats across the address space.

Top module: `ldst_lane_unit`

## Requirements
- R1: While reset is held, and after it until the first load, `load_data` is zero.
- R2: A word store (size 2'b10) followed by a word load from the same word address returns the stored 32-bit value.
- R3: A byte store (size 2'b00) sets exactly one bit of `wr_lane_en`, bit `addr[1:0]`. It drives `wr_lane_data` with `wdata[7:0]` on all four byte lanes and leaves the other three bytes of the word unchanged.
- R4: A halfword store (size 2'b01) sets `wr_lane_en` to 4'b1100 when `addr[1]` is 1 and to 4'b0011 otherwise. `addr[0]` is ignored. It drives `wdata[15:0]` onto both halves of `wr_lane_data` and leaves the other halfword unchanged.
- R5: A signed byte load (`is_unsigned`=0, size 2'b00) returns byte `addr[1:0]` of the word, with bit 7 of that byte copied into bits 31:8.
- R6: An unsigned byte load (`is_unsigned`=1, size 2'b00) returns byte `addr[1:0]` of the word, with bits 31:8 zero.
- R7: A halfword load returns bits 31:16 of the word when `addr[1]` is 1 and bits 15:0 otherwise. The upper 16 bits are copies of the halfword's bit 15 for a signed load and zeros for an unsigned load.
- R8: A word access (size 2'b10, or the spare code 2'b11) ignores `addr[1:0]` and `is_unsigned` and moves all 32 bits.
- R9: Only address bits [log2(MEM_BYTES)-1:2] select the word. Higher bits are ignored, so addresses that differ only above the range reach the same word.
- R10: When `req_valid` is low, `wr_lane_en` is 4'b0000 and the RAM contents do not change, whatever `req_write` and `wdata` are.
- R11: The load result for a request presented after a rising edge is valid on `load_data` before the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM acts on its falling edge |
| rst_n | input | 1 | Active-low asynchronous reset of the read register |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| is_unsigned | input | 1 | Zero-extend loads when 1, sign-extend when 0 |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Store data, right-aligned |
| wr_lane_en | output | 4 | Byte-lane write enables for the current store |
| wr_lane_data | output | 32 | Lane-replicated write word |
| load_data | output | 32 | Extracted and extended load result |

## Verification
The bench builds the block with MEM_BYTES = 256 and ADDR_W = 32, so the array has 64 words and the word index is bits [7:2]. This small depth brings aliasing within reach. A store to 0x130 and loads from 0x30 and 0xFFFFFF30 must all reach the same word, which shows that the upper address bits are ignored. The full 8 KB default has the same lane and extension logic and differs only in the index width.

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit #(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              is_unsigned,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [3:0]        wr_lane_en,
  output logic [31:0]       wr_lane_data,
  output logic [31:0]       load_data
);

  localparam int WORDS = MEM_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic [31:0]      mem [WORDS];
  logic [31:0]      rd_q;
  logic [IDX_W-1:0] idx;
  logic             unused_addr_hi;

  assign idx            = addr[IDX_W+1:2];
  assign unused_addr_hi = ^{addr[ADDR_W-1:IDX_W+2]};

  // store lane steering
  always_comb begin
    wr_lane_en   = 4'b0000;
    wr_lane_data = wdata;
    if (req_valid && req_write) begin
      case (req_size)
        SZ_BYTE: begin
          wr_lane_en   = 4'b0001 << addr[1:0];
          wr_lane_data = {4{wdata[7:0]}};
        end
        SZ_HALF: begin
          wr_lane_en   = addr[1] ? 4'b1100 : 4'b0011;
          wr_lane_data = {2{wdata[15:0]}};
        end
        default: wr_lane_en = 4'b1111;
      endcase
    end
  end

  // RAM on the falling edge
  always_ff @(negedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (wr_lane_en[l]) mem[idx][8*l +: 8] <= wr_lane_data[8*l +: 8];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_q <= '0;
    else if (req_valid && !req_write) rd_q <= mem[idx];
  end

  // load extraction and extension, after the read
  logic [31:0] byte_shift;
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  assign byte_shift = rd_q >> {addr[1:0], 3'b000};
  assign sel_byte   = byte_shift[7:0];
  assign sel_half   = addr[1] ? rd_q[31:16] : rd_q[15:0];

  always_comb begin
    case (req_size)
      SZ_BYTE: load_data = {{24{~is_unsigned & sel_byte[7]}}, sel_byte};
      SZ_HALF: load_data = {{16{~is_unsigned & sel_half[15]}}, sel_half};
      default: load_data = rd_q;
    endcase
  end

  // R10
  idle_no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> wr_lane_en == 4'b0000);

  // R3
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == SZ_BYTE) |->
      ($onehot0(wr_lane_en) && $countones(wr_lane_en) == 1));

  // R3
  byte_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == SZ_BYTE) |->
      (wr_lane_data[31:24] == wdata[7:0] && wr_lane_data[7:0] == wdata[7:0]));

  // R4
  half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size == SZ_HALF) |->
      $countones(wr_lane_en) == 2);

  // R6
  ubyte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_unsigned && req_size == SZ_BYTE) |->
      load_data[31:8] == 24'd0);

  // R5
  sbyte_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !is_unsigned && req_size == SZ_BYTE) |->
      load_data[31:8] == {24{load_data[7]}});

  // R7
  shalf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !is_unsigned && req_size == SZ_HALF) |->
      load_data[31:16] == {16{load_data[15]}});

endmodule

// File: tb/ldst_lane_unit_tb.sv
module ldst_lane_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic        is_unsigned = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wr_lane_en;
  logic [31:0] wr_lane_data;
  logic [31:0] load_data;

  int checks = 0;
  int fails  = 0;

  ldst_lane_unit #(.ADDR_W(32), .MEM_BYTES(256)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .is_unsigned(is_unsigned), .addr(addr), .wdata(wdata),
    .wr_lane_en(wr_lane_en), .wr_lane_data(wr_lane_data), .load_data(load_data));

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive after the rising edge, sample after the falling edge (R11)
  task automatic access(logic v, logic w, logic [1:0] sz, logic u,
                        logic [31:0] a, logic [31:0] d);
    @(posedge clk); #1;
    req_valid = v; req_write = w; req_size = sz; is_unsigned = u;
    addr = a; wdata = d;
    @(negedge clk); #1;
  endtask

  task automatic load_chk(string req, logic [1:0] sz, logic u,
                          logic [31:0] a, logic [31:0] exp);
    access(1'b1, 1'b0, sz, u, a, 32'h0);
    check(req, load_data, exp);
  endtask

  task automatic t_reset;
    #2 check("R1", load_data, 32'h0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", load_data, 32'h0);
  endtask

  task automatic t_word;
    access(1, 1, 2'b10, 0, 32'h10, 32'h8899AABB);
    check("R2", {28'h0, wr_lane_en}, 32'hF);
    load_chk("R2", 2'b10, 0, 32'h10, 32'h8899AABB);
    load_chk("R8", 2'b10, 1, 32'h13, 32'h8899AABB);
    access(1, 1, 2'b11, 0, 32'h40, 32'h01020304);
    load_chk("R8", 2'b10, 0, 32'h40, 32'h01020304);
  endtask

  task automatic t_byte_store;
    access(1, 1, 2'b00, 0, 32'h12, 32'h123456C5);
    check("R3", {28'h0, wr_lane_en}, 32'h4);
    check("R3", wr_lane_data, 32'hC5C5C5C5);
    load_chk("R3", 2'b10, 0, 32'h10, 32'h88C5AABB);
  endtask

  task automatic t_byte_load;
    load_chk("R5", 2'b00, 0, 32'h12, 32'hFFFFFFC5);
    load_chk("R5", 2'b00, 0, 32'h10, 32'hFFFFFFBB);
    load_chk("R5", 2'b00, 0, 32'h13, 32'hFFFFFF88);
    load_chk("R6", 2'b00, 1, 32'h12, 32'h000000C5);
    load_chk("R6", 2'b00, 1, 32'h11, 32'h000000AA);
    access(1, 1, 2'b10, 0, 32'h20, 32'h00417F22);
    load_chk("R5", 2'b00, 0, 32'h21, 32'h0000007F);
  endtask

  task automatic t_half;
    access(1, 1, 2'b01, 0, 32'h22, 32'h1234BEEF);
    check("R4", {28'h0, wr_lane_en}, 32'hC);
    check("R4", wr_lane_data, 32'hBEEFBEEF);
    load_chk("R4", 2'b10, 0, 32'h20, 32'hBEEF7F22);
    load_chk("R7", 2'b01, 0, 32'h22, 32'hFFFFBEEF);
    load_chk("R7", 2'b01, 1, 32'h22, 32'h0000BEEF);
    load_chk("R7", 2'b01, 0, 32'h20, 32'h00007F22);
    access(1, 1, 2'b10, 0, 32'h24, 32'h0);
    access(1, 1, 2'b01, 0, 32'h25, 32'h00008001);
    check("R4", {28'h0, wr_lane_en}, 32'h3);
    load_chk("R4", 2'b10, 0, 32'h24, 32'h00008001);
  endtask

  task automatic t_alias;
    access(1, 1, 2'b10, 0, 32'h130, 32'hCAFEF00D);
    load_chk("R9", 2'b10, 0, 32'h30, 32'hCAFEF00D);
    load_chk("R9", 2'b10, 0, 32'hFFFFFF30, 32'hCAFEF00D);
  endtask

  task automatic t_idle;
    access(0, 1, 2'b10, 0, 32'h30, 32'h11111111);
    check("R10", {28'h0, wr_lane_en}, 32'h0);
    access(0, 1, 2'b00, 0, 32'h31, 32'h22222222);
    check("R10", {28'h0, wr_lane_en}, 32'h0);
    load_chk("R10", 2'b10, 0, 32'h30, 32'hCAFEF00D);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_word();
        t_byte_store();
        t_byte_load();
        t_half();
        t_alias();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule